// File: doc/BRIEF.md
# Hiccup Overload Protection Sequencer

This block is the digital supervisor for a regulated output stage. It gates the stage's enable from an overload-detect input, the selected protection mode and the die temperature. In dynamic protection the block answers an overload with a timed retry loop. The output is held off for a long rest interval and then let back on, current-clamped, for a short probe interval. This repeats until a probe interval passes with no overload seen. In static protection the output stays on and clamped, and the overload flag simply follows the detector.

A thermal shutdown with hysteresis overrides both modes. While it is active, the retry timer is held at its idle state. Nothing runs until the power-on soft-start has reported completion. The rest and probe intervals are counted in ticks of a 1 ms strobe, and their lengths are parameters. The two temperature thresholds are also parameters, in whole degrees Celsius.

Top module: `hiccup_guard`

## Requirements
- R1: After reset, and until the soft-start-done strobe has been seen, `out_en`, `clamp_act`, `ovl_flag` and `therm_flag` are all 0, whatever the other inputs do.
- R2: In dynamic mode (`static_mode`=0) with the output running normally, an `ovl_det` sample of 1 makes `out_en` 0 and `ovl_flag` 1 from the next cycle.
- R3: The rest interval lasts exactly REST_TICKS `ms_tick` pulses, during which `out_en`=0. It is followed by a probe interval of PROBE_TICKS pulses, during which `out_en`=1 and `clamp_act`=1.
- R4: If `ovl_det` is 1 in any cycle of a probe interval, that interval is followed by a new rest interval. A probe interval with no overload returns to normal running: `out_en`=1, `clamp_act`=0, `ovl_flag`=0.
- R5: In static mode (`static_mode`=1), `out_en`=1 and `clamp_act`=1, and `ovl_flag` equals the value `ovl_det` had one cycle earlier.
- R6: Switching to static mode abandons any retry cycle in progress. Switching back to dynamic mode while `ovl_det`=1 starts a fresh rest interval on the next cycle.
- R7: A `temp_code` above HOT_C sets `therm_flag` from the next cycle. While `therm_flag`=1, `out_en`, `clamp_act` and `ovl_flag` are 0. The flag clears only after a sample at or below COOL_C; values in between hold it. The value HOT_C itself does not trip it.
- R8: When a thermal shutdown ends, the retry timer restarts from normal running, whatever phase it was in before the shutdown.
- R9: The cycle after the soft-start-done strobe, the output is enabled in normal running with `ovl_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| ovl_det | input | 1 | Overload detected by the current sense |
| static_mode | input | 1 | 1 selects static clamp mode, 0 selects dynamic retry mode |
| ss_done | input | 1 | Soft-start complete strobe |
| temp_code | input | TEMP_W | Junction temperature, unsigned whole °C |
| out_en | output | 1 | Enable for the output stage |
| clamp_act | output | 1 | Output runs under current clamp |
| ovl_flag | output | 1 | Overload status flag |
| therm_flag | output | 1 | Over-temperature status flag |

## Verification
The bench aims at the interval edges. A rest interval that ends one tick early or late, or a probe decision that samples only the last cycle, would release the output at the wrong time or miss a brief overload in the middle of the probe. Mode switches in the middle of a cycle are forced as well. A design that kept a stale rest phase after leaving static mode would keep the output dark with no overload present. The thermal thresholds are hit exactly at HOT_C, HOT_C+1, COOL_C+1 and COOL_C, which exposes a comparison off by one or missing hysteresis. A shutdown entered during a rest interval checks that the output returns at once when the shutdown ends, and does not resume the old rest countdown.

// File: rtl/hg_pkg.sv
package hg_pkg;

  typedef enum logic [1:0] {
    HG_RUN  = 2'd0,
    HG_REST = 2'd1,
    HG_PROBE = 2'd2
  } hg_phase_e;

  // True when the current tick closes an interval of lim ticks.
  function automatic logic hg_interval_done(input int unsigned cnt,
                                            input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

  // Hysteretic over-temperature latch: trip above hot, release at or below cool.
  function automatic logic hg_therm_next(input logic cur,
                                         input int unsigned t,
                                         input int unsigned hot,
                                         input int unsigned cool);
    if (t > hot)
      return 1'b1;
    else if (t <= cool)
      return 1'b0;
    else
      return cur;
  endfunction

endpackage

// File: rtl/hg_thermal.sv
module hg_thermal #(
  parameter int unsigned TEMP_W = 8,
  parameter int unsigned HOT_C  = 150,
  parameter int unsigned COOL_C = 130
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              armed,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              hot
);
  import hg_pkg::*;

  logic hot_q;

  always_ff @(posedge clk) begin
    if (rst || !armed)
      hot_q <= 1'b0;
    else
      hot_q <= hg_therm_next(hot_q, int'(temp_code), HOT_C, COOL_C);
  end

  assign hot = hot_q;

endmodule

// File: rtl/hg_retry.sv
module hg_retry #(
  parameter int unsigned REST_TICKS  = 900,
  parameter int unsigned PROBE_TICKS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              ms_tick,
  input  logic              ovl_det,
  output hg_pkg::hg_phase_e phase,
  output logic              rest_start,
  output logic              probe_fail
);
  import hg_pkg::*;

  localparam int unsigned MAXT = (REST_TICKS > PROBE_TICKS) ? REST_TICKS : PROBE_TICKS;
  localparam int unsigned CW   = $clog2(MAXT + 1);

  hg_phase_e         phase_q;
  logic [CW-1:0]     tick_cnt;
  logic              seen_q;
  logic              rest_end;
  logic              probe_end;

  assign rest_end   = (phase_q == HG_REST) && ms_tick &&
                      hg_interval_done(int'(tick_cnt), REST_TICKS);
  assign probe_end  = (phase_q == HG_PROBE) && ms_tick &&
                      hg_interval_done(int'(tick_cnt), PROBE_TICKS);
  assign probe_fail = probe_end && (seen_q || ovl_det);
  assign rest_start = !hold && (((phase_q == HG_RUN) && ovl_det) || probe_fail);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      phase_q  <= HG_RUN;
      tick_cnt <= '0;
      seen_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        HG_RUN: begin
          tick_cnt <= '0;
          seen_q   <= 1'b0;
          if (ovl_det)
            phase_q <= HG_REST;
        end
        HG_REST: begin
          seen_q <= 1'b0;
          if (rest_end) begin
            phase_q  <= HG_PROBE;
            tick_cnt <= '0;
          end else if (ms_tick) begin
            tick_cnt <= tick_cnt + 1'b1;
          end
        end
        HG_PROBE: begin
          if (probe_end) begin
            phase_q  <= probe_fail ? HG_REST : HG_RUN;
            tick_cnt <= '0;
            seen_q   <= 1'b0;
          end else begin
            seen_q <= seen_q || ovl_det;
            if (ms_tick)
              tick_cnt <= tick_cnt + 1'b1;
          end
        end
        default: begin
          phase_q  <= HG_RUN;
          tick_cnt <= '0;
          seen_q   <= 1'b0;
        end
      endcase
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/hiccup_guard.sv
module hiccup_guard #(
  parameter int unsigned REST_TICKS  = 900,
  parameter int unsigned PROBE_TICKS = 20,
  parameter int unsigned TEMP_W      = 8,
  parameter int unsigned HOT_C       = 150,
  parameter int unsigned COOL_C      = 130
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic              ovl_det,
  input  logic              static_mode,
  input  logic              ss_done,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              out_en,
  output logic              clamp_act,
  output logic              ovl_flag,
  output logic              therm_flag
);
  import hg_pkg::*;

  logic      ready_q;
  logic      hot;
  logic      live;
  logic      seq_hold;
  logic      static_ovl_q;
  logic      rest_start;
  logic      probe_fail;
  hg_phase_e phase;

  always_ff @(posedge clk) begin
    if (rst)
      ready_q <= 1'b0;
    else if (ss_done)
      ready_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      static_ovl_q <= 1'b0;
    else
      static_ovl_q <= ovl_det;
  end

  hg_thermal #(
    .TEMP_W (TEMP_W),
    .HOT_C  (HOT_C),
    .COOL_C (COOL_C)
  ) u_thermal (
    .clk       (clk),
    .rst       (rst),
    .armed     (ready_q),
    .temp_code (temp_code),
    .hot       (hot)
  );

  assign live     = ready_q && !hot;
  assign seq_hold = !live || static_mode;

  hg_retry #(
    .REST_TICKS  (REST_TICKS),
    .PROBE_TICKS (PROBE_TICKS)
  ) u_retry (
    .clk        (clk),
    .rst        (rst),
    .hold       (seq_hold),
    .ms_tick    (ms_tick),
    .ovl_det    (ovl_det),
    .phase      (phase),
    .rest_start (rest_start),
    .probe_fail (probe_fail)
  );

  always_comb begin
    out_en    = 1'b0;
    clamp_act = 1'b0;
    ovl_flag  = 1'b0;
    if (live) begin
      if (static_mode) begin
        out_en    = 1'b1;
        clamp_act = 1'b1;
        ovl_flag  = static_ovl_q;
      end else begin
        out_en    = (phase != HG_REST);
        clamp_act = (phase == HG_PROBE);
        ovl_flag  = (phase != HG_RUN);
      end
    end
  end

  assign therm_flag = hot;

endmodule

// File: rtl/hiccup_guard_chk.sv
module hiccup_guard_chk #(
  parameter int unsigned TEMP_W = 8,
  parameter int unsigned HOT_C  = 150
) (
  input logic              clk,
  input logic              rst,
  input logic              ready_q,
  input logic              static_mode,
  input logic              ovl_det,
  input logic [TEMP_W-1:0] temp_code,
  input logic              rest_start,
  input logic              out_en,
  input logic              clamp_act,
  input logic              ovl_flag,
  input logic              therm_flag
);

  AST_IDLE_BEFORE_SS: assert property (@(posedge clk) disable iff (rst)
    !ready_q |-> !out_en && !clamp_act && !ovl_flag && !therm_flag); // R1

  AST_THERM_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    therm_flag |-> !out_en && !clamp_act && !ovl_flag); // R7

  AST_THERM_TRIP: assert property (@(posedge clk) disable iff (rst)
    (ready_q && int'(temp_code) > HOT_C) |=> therm_flag); // R7

  AST_STATIC_ON: assert property (@(posedge clk) disable iff (rst)
    (static_mode && ready_q && !therm_flag) |-> out_en && clamp_act); // R5

  AST_DYN_CUTOFF: assert property (@(posedge clk) disable iff (rst)
    (rest_start && int'(temp_code) <= HOT_C) |=> (!out_en || static_mode)); // R2

  AST_RUN_UNCLAMPED: assert property (@(posedge clk) disable iff (rst)
    (ready_q && !therm_flag && !static_mode && !ovl_flag) |-> out_en && !clamp_act); // R4

endmodule

bind hiccup_guard hiccup_guard_chk #(
  .TEMP_W (TEMP_W),
  .HOT_C  (HOT_C)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ready_q     (ready_q),
  .static_mode (static_mode),
  .ovl_det     (ovl_det),
  .temp_code   (temp_code),
  .rest_start  (rest_start),
  .out_en      (out_en),
  .clamp_act   (clamp_act),
  .ovl_flag    (ovl_flag),
  .therm_flag  (therm_flag)
);

// File: tb/test_hiccup_guard.sv
`timescale 1ns/1ps
module test_hiccup_guard;

  localparam int unsigned RT = 9;
  localparam int unsigned PT = 3;
  localparam int unsigned TW = 8;
  localparam int unsigned HOT = 150;
  localparam int unsigned COOL = 130;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0;
  logic ovl_det = 1'b0;
  logic static_mode = 1'b0;
  logic ss_done = 1'b0;
  logic [TW-1:0] temp_code = 8'd25;
  logic out_en, clamp_act, ovl_flag, therm_flag;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hiccup_guard #(
    .REST_TICKS (RT), .PROBE_TICKS (PT), .TEMP_W (TW), .HOT_C (HOT), .COOL_C (COOL)
  ) i_hiccup_guard (
    .clk (clk), .rst (rst), .ms_tick (ms_tick), .ovl_det (ovl_det),
    .static_mode (static_mode), .ss_done (ss_done), .temp_code (temp_code),
    .out_en (out_en), .clamp_act (clamp_act), .ovl_flag (ovl_flag),
    .therm_flag (therm_flag)
  );

  // Reference model: 0 running, 1 resting, 2 probing; counts remaining ticks down.
  bit m_ready, m_hot, m_sovl, m_dirty;
  int m_mode_ph, m_left;

  always @(posedge clk) begin
    if (rst) begin
      m_ready <= 0; m_hot <= 0; m_sovl <= 0; m_mode_ph <= 0; m_left <= 0; m_dirty <= 0;
    end else begin
      if (ss_done) m_ready <= 1;
      m_sovl <= ovl_det;
      if (!m_ready) m_hot <= 0;
      else if (temp_code > HOT) m_hot <= 1;
      else if (temp_code <= COOL) m_hot <= 0;
      if (!m_ready || m_hot || static_mode) begin
        m_mode_ph <= 0; m_dirty <= 0;
      end else if (m_mode_ph == 0) begin
        if (ovl_det) begin m_mode_ph <= 1; m_left <= RT; end
      end else if (m_mode_ph == 1) begin
        if (ms_tick) begin
          if (m_left == 1) begin m_mode_ph <= 2; m_left <= PT; m_dirty <= 0; end
          else m_left <= m_left - 1;
        end
      end else begin
        if (ms_tick && m_left == 1) begin
          if (m_dirty || ovl_det) begin m_mode_ph <= 1; m_left <= RT; end
          else m_mode_ph <= 0;
          m_dirty <= 0;
        end else begin
          m_dirty <= m_dirty || ovl_det;
          if (ms_tick) m_left <= m_left - 1;
        end
      end
    end
  end

  function automatic bit exp_en();
    return m_ready && !m_hot && (static_mode || m_mode_ph != 1);
  endfunction
  function automatic bit exp_clamp();
    return m_ready && !m_hot && (static_mode || m_mode_ph == 2);
  endfunction
  function automatic bit exp_flag();
    if (!m_ready || m_hot) return 0;
    return static_mode ? m_sovl : (m_mode_ph != 0);
  endfunction
  function automatic string ctx_tag();
    if (!m_ready) return "R1";
    if (m_hot) return "R7";
    if (static_mode) return "R5";
    return "R3";
  endfunction

  task automatic chk(input string tag, input string what, input bit act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_cmp();
    chk(ctx_tag(), "out_en", out_en, exp_en());
    chk(ctx_tag(), "clamp_act", clamp_act, exp_clamp());
    chk(ctx_tag(), "ovl_flag", ovl_flag, exp_flag());
    chk("R7", "therm_flag", therm_flag, m_hot);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_cmp();
    end
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) begin
      ms_tick = 1; run(1); ms_tick = 0; run(1);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d cycles expected=<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    run(3);
    chk("R1", "reset out_en", out_en, 0);
    chk("R1", "reset therm", therm_flag, 0);
    rst = 0; ovl_det = 1; temp_code = 8'd170;
    run(4);
    chk("R1", "pre-ss out_en", out_en, 0);
    chk("R1", "pre-ss flags", ovl_flag | therm_flag, 0);
    ovl_det = 0; temp_code = 8'd25; ss_done = 1; run(1); ss_done = 0;
    chk("R9", "ss out_en", out_en, 1);
    chk("R9", "ss flag", ovl_flag, 0);
    ovl_det = 1; run(1); ovl_det = 0;
    chk("R2", "overload out_en", out_en, 0);
    chk("R2", "overload flag", ovl_flag, 1);
    ticks(RT - 1);
    chk("R3", "rest not over", out_en, 0);
    ticks(1);
    chk("R3", "probe out_en", out_en, 1);
    chk("R3", "probe clamp", clamp_act, 1);
    ovl_det = 1; run(1); ovl_det = 0;
    ticks(PT);
    chk("R4", "dirty probe rests", out_en, 0);
    chk("R4", "dirty probe flag", ovl_flag, 1);
    ticks(RT + PT);
    chk("R4", "clean probe runs", out_en, 1);
    chk("R4", "clean probe clamp", clamp_act, 0);
    chk("R4", "clean probe flag", ovl_flag, 0);
    ovl_det = 1; run(1);
    chk("R2", "second overload", out_en, 0);
    static_mode = 1; run(1);
    chk("R6", "static abandons", out_en, 1);
    chk("R5", "static flag high", ovl_flag, 1);
    ovl_det = 0; run(1);
    chk("R5", "static flag low", ovl_flag, 0);
    chk("R5", "static clamp", clamp_act, 1);
    ovl_det = 1; run(1);
    static_mode = 0; run(1); ovl_det = 0;
    chk("R6", "dyn restart out_en", out_en, 0);
    chk("R6", "dyn restart flag", ovl_flag, 1);
    temp_code = 8'd150; run(2);
    chk("R7", "150 no trip", therm_flag, 0);
    temp_code = 8'd151; run(1);
    chk("R7", "151 trips", therm_flag, 1);
    chk("R7", "trip gates flag", ovl_flag, 0);
    temp_code = 8'd131; run(2);
    chk("R7", "131 holds", therm_flag, 1);
    temp_code = 8'd130; run(1);
    chk("R7", "130 clears", therm_flag, 0);
    chk("R8", "fresh run after trip", out_en, 1);
    chk("R8", "fresh flag after trip", ovl_flag, 0);

    for (int c = 0; c < 40000; c++) begin
      ms_tick = ($urandom % 3) == 0;
      if (($urandom % 10) == 0) ovl_det = ($urandom % 3) == 0;
      if (($urandom % 400) == 0) static_mode = ~static_mode;
      if (($urandom % 300) == 0) temp_code = TW'(120 + $urandom % 40);
      else if (($urandom % 300) == 0) temp_code = TW'(20 + $urandom % 100);
      ss_done = ($urandom % 700) == 0;
      rst = ($urandom % 9000) == 0;
      run(1);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule